// File: doc/BRIEF.md
# Reconfigurable Split/Cascade Timer with Capture

This block is a counter pair of two equal halves. Together they give one wide timer/counter or two independent narrow ones. A two-bit mode field picks the arrangement:

- two prescaled timers;
- a prescaled timer in the low half with an event counter in the high half;
- one wide prescaled timer;
- one wide event counter.

Each half has its own programmable clock divider. Both halves share one capture register, whose width follows the mode. The block is meant to sit behind a peripheral register decoder. Software writes the mode, the divider limits and the match value through a small write port. Software reads the live count and the captured value as plain outputs.

Each counter compares itself against its match value. When it is at that value and a count enable arrives, it reloads to zero and raises a one-cycle interrupt request on its half's flag output. In the wide arrangements only the high flag is used. The event and capture strobe inputs arrive already synchronised and reduced to one-cycle pulses.

Top module: `cascade_timer`

## Requirements
- R1: While reset is asserted, `count_o`, `capture_o`, `flag_lo_o` and `flag_hi_o` are all zero. Reset also sets the mode to 0, both divider limits to 0 and the match value to all ones.
- R2: A divider with limit P produces a count enable every P+1 cycles. It emits the enable in the cycle where its internal count is greater than or equal to P, then restarts from zero. Writing `wr_sel_i`=1 sets the low limit and `wr_sel_i`=2 sets the high limit, each from the low PRE_W bits of `wr_data_i`.
- R3: In mode 0 (`wr_data_i[1:0]`=0 written with `wr_sel_i`=0), the low half advances on the low divider and the high half advances on the high divider, independently.
- R4: In mode 1, the low half advances on the low divider and the high half advances once per cycle in which `evt_i` is high.
- R5: In mode 2, `count_o` is one 2·HALF_W-bit counter advanced by the low divider. The high half steps when the low half is all ones.
- R6: In mode 3, `count_o` is one 2·HALF_W-bit counter advanced once per cycle in which `evt_i` is high.
- R7: `wr_sel_i`=3 loads the match value from `wr_data_i`; the low HALF_W bits belong to the low half and the upper bits to the high half. A counter that receives a count enable while equal to its match value becomes zero at that edge, and its flag is high for exactly the following cycle.
- R8: In modes 2 and 3, `flag_lo_o` stays zero. `flag_hi_o` reports the wide match.
- R9: In modes 0 and 1, `cap_lo_i` copies the low half of the count into `capture_o`'s low half, and `cap_hi_i` copies the high half into `capture_o`'s high half. The other half of `capture_o` keeps its value.
- R10: In modes 2 and 3, either capture strobe copies the whole count into `capture_o`.
- R11: A capture in the same cycle as a count enable stores the count value from before that increment.
- R12: Writing the mode clears both counters and both dividers at that edge. No flag results from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | One-cycle external event pulse |
| cap_lo_i | input | 1 | Low-half capture strobe |
| cap_hi_i | input | 1 | High-half capture strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select: 0 mode, 1 low limit, 2 high limit, 3 match |
| wr_data_i | input | 2·HALF_W | Register write data |
| count_o | output | 2·HALF_W | Live count, high half above low half |
| capture_o | output | 2·HALF_W | Capture register |
| flag_lo_o | output | 1 | Low-half match interrupt pulse |
| flag_hi_o | output | 1 | High-half or wide match interrupt pulse |

## Verification
The bench builds the block with HALF_W=4 and PRE_W=3. With these values the whole count spans only 256 states and a divider limit tops out at 7. Natural wraparound of each half, the carry from the low into the high half, and the wide wrap all come within a few hundred cycles. The narrow halves also make divider limits that drop below the running divider count reachable. Every mode runs with these patterns:

- event and capture strobes that coincide with count enables;
- match values at zero, in the middle and at all ones;
- a mode rewrite in the middle of a run.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT_TMR = 2'd0,
    MODE_TMR_EVT   = 2'd1,
    MODE_WIDE_TMR  = 2'd2,
    MODE_WIDE_EVT  = 2'd3
  } tmode_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_PRE_LO = 2'd1;
  localparam logic [1:0] SEL_PRE_HI = 2'd2;
  localparam logic [1:0] SEL_MATCH  = 2'd3;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_q, cnt_d;

  // terminal test uses >= so a limit lowered below the running count
  // still terminates at once instead of wrapping the whole range
  assign tick_o = (cnt_q >= limit_i);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr_i || tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: after a terminal tick the divider restarts from zero
  assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/half_counter.sv
module half_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (reload_i) cnt_d = '0;
    else if (step_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R12: a clear zeroes the half at the next edge
  assert_clear_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

  // R3: a plain step advances by exactly one
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reload_i && !clr_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

  // R7: a reload zeroes the half at the next edge
  assert_reload_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !clr_i) |=> (cnt_o == '0));

endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [2*HALF_W-1:0] value_i,
  output logic [2*HALF_W-1:0] cap_o
);

  localparam int DW = 2 * HALF_W;

  logic              ld_lo, ld_hi;
  logic [DW-1:0]     cap_q, cap_d;

  assign ld_lo = cap_lo_i | (wide_i & cap_hi_i);
  assign ld_hi = cap_hi_i | (wide_i & cap_lo_i);

  always_comb begin
    cap_d = cap_q;
    if (ld_lo) cap_d[HALF_W-1:0]  = value_i[HALF_W-1:0];
    if (ld_hi) cap_d[DW-1:HALF_W] = value_i[DW-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap_o = cap_q;

  // R10: in a wide mode either strobe takes the full value
  assert_wide_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_i && (cap_lo_i || cap_hi_i)) |=> (cap_o == $past(value_i)));

  // R9: a lone low strobe in split mode leaves the high half alone
  assert_split_keep_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && cap_lo_i && !cap_hi_i) |=>
      (cap_o[DW-1:HALF_W] == $past(cap_o[DW-1:HALF_W])));

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evt_i,
  input  logic                cap_lo_i,
  input  logic                cap_hi_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [2*HALF_W-1:0] wr_data_i,
  output logic [2*HALF_W-1:0] count_o,
  output logic [2*HALF_W-1:0] capture_o,
  output logic                flag_lo_o,
  output logic                flag_hi_o
);

  localparam int DW = 2 * HALF_W;

  // configuration registers
  tmode_e            mode_q, mode_d;
  logic [PRE_W-1:0]  pre_q [2];
  logic [PRE_W-1:0]  pre_d [2];
  logic [DW-1:0]     match_q, match_d;

  logic mode_wr;
  assign mode_wr = wr_en_i && (wr_sel_i == SEL_MODE);

  always_comb begin
    mode_d  = mode_q;
    pre_d   = pre_q;
    match_d = match_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_MODE:   mode_d   = tmode_e'(wr_data_i[1:0]);
        SEL_PRE_LO: pre_d[0] = wr_data_i[PRE_W-1:0];
        SEL_PRE_HI: pre_d[1] = wr_data_i[PRE_W-1:0];
        default:    match_d  = wr_data_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SPLIT_TMR;
      pre_q   <= '{default: '0};
      match_q <= '1;
    end else begin
      mode_q  <= mode_d;
      pre_q   <= pre_d;
      match_q <= match_d;
    end
  end

  // one divider per half
  logic [1:0] tick;

  for (genvar g = 0; g < 2; g++) begin : g_div
    tick_divider #(.PRE_W(PRE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (mode_wr),
      .limit_i (pre_q[g]),
      .tick_o  (tick[g])
    );
  end

  // count enable routing per mode
  logic wide, lo_en, hi_en, wide_en;
  logic [HALF_W-1:0] lo_cnt, hi_cnt;
  logic lo_hit, hi_hit, full_hit, lo_full;

  assign wide = mode_q[1];

  always_comb begin
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    wide_en = 1'b0;
    case (mode_q)
      MODE_SPLIT_TMR: begin lo_en = tick[0]; hi_en = tick[1]; end
      MODE_TMR_EVT:   begin lo_en = tick[0]; hi_en = evt_i;   end
      MODE_WIDE_TMR:  wide_en = tick[0];
      default:        wide_en = evt_i;
    endcase
  end

  assign lo_hit   = (lo_cnt == match_q[HALF_W-1:0]);
  assign hi_hit   = (hi_cnt == match_q[DW-1:HALF_W]);
  assign full_hit = lo_hit && hi_hit;
  assign lo_full  = &lo_cnt;

  logic lo_step, lo_reload, hi_step, hi_reload;

  always_comb begin
    if (wide) begin
      lo_step   = wide_en;
      lo_reload = wide_en && full_hit;
      hi_step   = wide_en && lo_full;
      hi_reload = wide_en && full_hit;
    end else begin
      lo_step   = lo_en;
      lo_reload = lo_en && lo_hit;
      hi_step   = hi_en;
      hi_reload = hi_en && hi_hit;
    end
  end

  half_counter #(.W(HALF_W)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (mode_wr),
    .step_i   (lo_step),
    .reload_i (lo_reload),
    .cnt_o    (lo_cnt)
  );

  half_counter #(.W(HALF_W)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (mode_wr),
    .step_i   (hi_step),
    .reload_i (hi_reload),
    .cnt_o    (hi_cnt)
  );

  assign count_o = {hi_cnt, lo_cnt};

  // interrupt request pulses
  logic flag_lo_q, flag_lo_d, flag_hi_q, flag_hi_d;

  always_comb begin
    flag_lo_d = !mode_wr && !wide && lo_reload;
    flag_hi_d = !mode_wr && hi_reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo_q <= 1'b0;
      flag_hi_q <= 1'b0;
    end else begin
      flag_lo_q <= flag_lo_d;
      flag_hi_q <= flag_hi_d;
    end
  end

  assign flag_lo_o = flag_lo_q;
  assign flag_hi_o = flag_hi_q;

  capture_bank #(.HALF_W(HALF_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide_i   (wide),
    .cap_lo_i (cap_lo_i),
    .cap_hi_i (cap_hi_i),
    .value_i  (count_o),
    .cap_o    (capture_o)
  );

  // R8: no low flag while a wide mode is active
  assert_lo_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !flag_lo_o);

  // R7: a high flag always follows a reload of the high half
  assert_flag_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hi_o |-> (hi_cnt == '0));

  // R12: a mode write leaves the whole count at zero and no flag
  assert_mode_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (count_o == '0) && !flag_lo_o && !flag_hi_o);

endmodule

// File: tb/cascade_timer_test.sv
`timescale 1ns/1ps
module cascade_timer_test;

  localparam int HW = 4;
  localparam int PW = 3;
  localparam int DW = 2 * HW;
  localparam int H  = 1 << HW;

  logic clk = 1'b0;
  logic rst_n;
  logic evt, cap_lo, cap_hi, wr_en;
  logic [1:0] wr_sel;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] count_o, capture_o;
  logic flag_lo_o, flag_hi_o;

  always #5 clk = ~clk;

  cascade_timer #(.HALF_W(HW), .PRE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .count_o(count_o), .capture_o(capture_o),
    .flag_lo_o(flag_lo_o), .flag_hi_o(flag_hi_o)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string req = "R1";

  // reference model state
  int m_mode, m_match, m_lo, m_hi, m_cap, m_flo, m_fhi;
  int m_pre [2];
  int m_pc  [2];

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk("count", int'(count_o), m_hi * H + m_lo);
    chk("capture", int'(capture_o), m_cap);
    chk("flag_lo", int'(flag_lo_o), m_flo);
    chk("flag_hi", int'(flag_hi_o), m_fhi);
  endtask

  // advance model and design by one edge, then compare
  task automatic step();
    int t0, t1, lo_en, hi_en, w_en, v, mw, nflo, nfhi;
    t0 = (m_pc[0] >= m_pre[0]);
    t1 = (m_pc[1] >= m_pre[1]);
    mw = (wr_en && wr_sel == 2'd0);
    lo_en = 0; hi_en = 0; w_en = 0;
    case (m_mode)
      0: begin lo_en = t0; hi_en = t1; end
      1: begin lo_en = t0; hi_en = int'(evt); end
      2: w_en = t0;
      default: w_en = int'(evt);
    endcase
    // capture sees the values before this edge (R11)
    if (m_mode >= 2) begin
      if (cap_lo || cap_hi) m_cap = m_hi * H + m_lo;
    end else begin
      if (cap_lo) m_cap = (m_cap / H) * H + m_lo;
      if (cap_hi) m_cap = (m_cap % H) + m_hi * H;
    end
    nflo = 0; nfhi = 0;
    if (mw) begin
      m_lo = 0; m_hi = 0; m_pc[0] = 0; m_pc[1] = 0;
    end else begin
      if (m_mode < 2) begin
        if (lo_en) begin
          if (m_lo == m_match % H) begin m_lo = 0; nflo = 1; end
          else m_lo = (m_lo + 1) % H;
        end
        if (hi_en) begin
          if (m_hi == m_match / H) begin m_hi = 0; nfhi = 1; end
          else m_hi = (m_hi + 1) % H;
        end
      end else if (w_en) begin
        v = m_hi * H + m_lo;
        if (v == m_match) begin v = 0; nfhi = 1; end
        else v = (v + 1) % (H * H);
        m_lo = v % H; m_hi = v / H;
      end
      m_pc[0] = t0 ? 0 : m_pc[0] + 1;
      m_pc[1] = t1 ? 0 : m_pc[1] + 1;
    end
    m_flo = nflo; m_fhi = nfhi;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_mode = int'(wr_data[1:0]);
        2'd1: m_pre[0] = int'(wr_data[PW-1:0]);
        2'd2: m_pre[1] = int'(wr_data[PW-1:0]);
        default: m_match = int'(wr_data);
      endcase
    end
    @(posedge clk);
    #1;
    cycles++;
    compare();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, int data);
    wr_en = 1'b1; wr_sel = sel; wr_data = DW'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic run(int n, int evt_div, int cap_div);
    for (int i = 0; i < n; i++) begin
      evt    = (evt_div > 0) && (i % evt_div == 0);
      cap_lo = (cap_div > 0) && (i % cap_div == 1);
      cap_hi = (cap_div > 0) && (i % cap_div == 2 || i % cap_div == 1 && i % 2 == 0);
      step();
    end
    evt = 1'b0; cap_lo = 1'b0; cap_hi = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; evt = 0; cap_lo = 0; cap_hi = 0;
    wr_en = 0; wr_sel = 0; wr_data = '0;
    m_mode = 0; m_match = H * H - 1; m_lo = 0; m_hi = 0; m_cap = 0;
    m_flo = 0; m_fhi = 0; m_pre[0] = 0; m_pre[1] = 0; m_pc[0] = 0; m_pc[1] = 0;
    repeat (3) @(negedge clk);
    req = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    // one edge has passed since release with all inputs idle; replay it in the model
    m_lo = 1; m_hi = 1; cycles++;
    req = "R1"; compare();

    req = "R3"; wr(2'd1, 2); wr(2'd2, 4); wr(2'd0, 0); run(60, 0, 0);
    req = "R2"; wr(2'd1, 0); run(20, 0, 0); wr(2'd2, 7); run(5, 0, 0);
    wr(2'd2, 1); run(30, 0, 0);
    req = "R7"; wr(2'd3, 16'h35); run(120, 0, 0);
    req = "R4"; wr(2'd0, 1); wr(2'd1, 3); run(150, 3, 0);
    req = "R9"; run(120, 2, 5);
    req = "R11"; run(60, 1, 3);
    req = "R5"; wr(2'd3, H * H - 1); wr(2'd1, 1); wr(2'd0, 2); run(600, 0, 0);
    req = "R10"; run(100, 0, 7);
    req = "R8"; wr(2'd3, 16'h25); run(200, 0, 9);
    req = "R6"; wr(2'd0, 3); run(200, 2, 0);
    req = "R11"; run(100, 1, 4);
    req = "R12"; wr(2'd0, 0); run(10, 0, 0); wr(2'd0, 3); run(12, 1, 0);
    wr(2'd3, 0); run(20, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule